// File: doc/BRIEF.md
# Supply brown-out guard controller

This block is the digital side of a supply-voltage monitor. An analog comparator, outside the block, reports whether the core supply has dropped below a selectable threshold. The block holds the monitor's configuration: an operating mode, a threshold level and a hysteresis enable. It also turns the comparator result into a status flag, an interrupt pulse or a reset request, depending on the mode.

The configuration is taken from fuse inputs whenever the block is reset. Software may change it afterwards through a simple write strobe. When the monitor is switched on, the comparator result is blanked while the analog circuit settles. The window ends at the first transition of the slow oscillator clock after the enable, plus a fixed number of main clock cycles. While a debug port is active, the reset request and the interrupt are held off.

A calibration-done flag tracks whether flash calibration has run. The first brown-out reset with the flag clear asks for calibration and restores the fuse configuration. Later brown-outs leave the configuration as it is.

Top module: `supply_guard`

## Requirements
- R1: On synchronous reset, mode_o, hyst_en_o and level_o take the fuse input values. det_o, irq_o, rst_req_o, cal_req_o and cal_flag_o are 0.
- R2: Mode 0 (off) and mode 3 (reserved) disable the monitor: det_o and rst_req_o stay 0 whatever the comparator does.
- R3: In mode 2 (flag), det_o equals the comparator input (1 = supply below threshold) delayed by three main clock edges: two synchronizer flops and one output register. It therefore clears by itself when the supply recovers.
- R4: irq_o is a one-cycle pulse, registered together with det_o, only on a 0-to-1 change of det_o.
- R5: In mode 1 (reset), rst_req_o follows the comparator with the same three-edge latency, and det_o stays 0.
- R6: When the mode changes from inactive to 1 or 2, the comparator is ignored until a change of the synchronized slow clock has been seen and MAIN_HOLD (default 2) further main cycles have passed. With the default parameters, det_o rises at the sixth edge after the slow clock toggles.
- R7: While dbg_active_i is high, rst_req_o and irq_o are 0 at the following edge. det_o still follows the comparator.
- R8: A write (wr_en_i high for one cycle) updates mode_o and hyst_en_o at that edge. hyst_en_o is the hysteresis control sent to the comparator.
- R9: A write updates level_o only if the current mode is 0 or 3. While the monitor is active, the level field of a write is ignored.
- R10: When rst_req_o rises while cal_flag_o is 0, cal_req_o pulses for one cycle and all three fields reload from the fuses at the same edge. cal_flag_o becomes 1 after cal_done_i is seen. A later rise of rst_req_o with cal_flag_o at 1 gives no pulse and keeps the fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_clk_i | input | 1 | Slow oscillator clock, sampled as data |
| cmp_below_i | input | 1 | Comparator result, 1 when the supply is below the threshold (asynchronous) |
| dbg_active_i | input | 1 | Debug port active; masks reset request and interrupt |
| fuse_mode_i | input | 2 | Fuse value for the mode |
| fuse_hyst_i | input | 1 | Fuse value for the hysteresis enable |
| fuse_level_i | input | LVL_W | Fuse value for the threshold level |
| wr_en_i | input | 1 | Software write strobe |
| wr_mode_i | input | 2 | Mode to write |
| wr_hyst_i | input | 1 | Hysteresis enable to write |
| wr_level_i | input | LVL_W | Level to write |
| cal_done_i | input | 1 | Flash calibration finished |
| mode_o | output | 2 | Current mode |
| hyst_en_o | output | 1 | Hysteresis enable to the comparator |
| level_o | output | LVL_W | Threshold select to the comparator |
| det_o | output | 1 | Brown-out detect status (mode 2) |
| irq_o | output | 1 | Interrupt pulse on a new detection |
| rst_req_o | output | 1 | Brown-out reset request (mode 1) |
| cal_req_o | output | 1 | One-cycle calibration request |
| cal_flag_o | output | 1 | Calibration-done flag |

## Verification
The embedded assertions check, on every cycle, that the off modes keep the outputs quiet, that an interrupt only comes with a fresh detection, and that debug masking takes effect at the next edge. They also check that the blanking window suppresses outputs, that the calibration request lasts one cycle, and that the level is frozen while active. The exact latency of the detect path and the length of the settling window after a slow-clock change are only shown by the bench's directed sequences. So are the fuse reload on the first brown-out and the kept configuration on a later one. A seeded random phase compares det_o and irq_o against a delayed model of the comparator while debug toggles.

// File: rtl/sg_pkg.sv
package sg_pkg;
  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_RESET = 2'd1,
    MODE_FLAG  = 2'd2,
    MODE_RSVD  = 2'd3
  } sg_mode_e;

  function automatic logic mode_active(input logic [1:0] m);
    return (m == MODE_RESET) || (m == MODE_FLAG);
  endfunction
endpackage

// File: rtl/sg_sync.sv
module sg_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stage_q;

  always_ff @(posedge clk) begin
    if (rst) stage_q <= '0;
    else     stage_q <= {stage_q[STAGES-2:0], d_i};
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/sg_cfg.sv
module sg_cfg
  import sg_pkg::*;
#(
  parameter int LVL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reload_i,
  input  logic [1:0]       fuse_mode_i,
  input  logic             fuse_hyst_i,
  input  logic [LVL_W-1:0] fuse_level_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_mode_i,
  input  logic             wr_hyst_i,
  input  logic [LVL_W-1:0] wr_level_i,
  output logic [1:0]       mode_o,
  output logic             hyst_o,
  output logic [LVL_W-1:0] level_o
);
  always_ff @(posedge clk) begin
    if (rst || reload_i) begin
      mode_o  <= fuse_mode_i;
      hyst_o  <= fuse_hyst_i;
      level_o <= fuse_level_i;
    end else if (wr_en_i) begin
      mode_o <= wr_mode_i;
      hyst_o <= wr_hyst_i;
      // threshold may only move while the monitor is off
      if (!mode_active(mode_o)) level_o <= wr_level_i;
    end
  end

  assert_level_lock_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && mode_active(mode_o) && !reload_i) |=> $stable(level_o));
endmodule

// File: rtl/sg_settle.sv
module sg_settle #(
  parameter int MAIN_HOLD = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic active_i,
  input  logic slow_edge_i,
  output logic blank_o
);
  localparam int CNT_W = (MAIN_HOLD < 2) ? 1 : $clog2(MAIN_HOLD + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT_SLOW, ST_HOLD} settle_e;

  settle_e          state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             active_q;
  logic             start;

  assign start = active_i && !active_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else begin
      active_q <= active_i;
      if (!active_i) begin
        state_q <= ST_IDLE;
      end else if (start) begin
        state_q <= ST_WAIT_SLOW;
      end else begin
        case (state_q)
          ST_WAIT_SLOW: if (slow_edge_i) begin
            state_q <= ST_HOLD;
            cnt_q   <= '0;
          end
          ST_HOLD: begin
            if (cnt_q == CNT_W'(MAIN_HOLD - 1)) state_q <= ST_IDLE;
            else                                cnt_q   <= cnt_q + 1'b1;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign blank_o = start || (state_q != ST_IDLE);

  assert_wait_holds_R6: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAIT_SLOW && active_i && !slow_edge_i) |=> blank_o);
endmodule

// File: rtl/supply_guard.sv
module supply_guard
  import sg_pkg::*;
#(
  parameter int LVL_W       = 4,
  parameter int SYNC_STAGES = 2,
  parameter int MAIN_HOLD   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             slow_clk_i,
  input  logic             cmp_below_i,
  input  logic             dbg_active_i,
  input  logic [1:0]       fuse_mode_i,
  input  logic             fuse_hyst_i,
  input  logic [LVL_W-1:0] fuse_level_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_mode_i,
  input  logic             wr_hyst_i,
  input  logic [LVL_W-1:0] wr_level_i,
  input  logic             cal_done_i,
  output logic [1:0]       mode_o,
  output logic             hyst_en_o,
  output logic [LVL_W-1:0] level_o,
  output logic             det_o,
  output logic             irq_o,
  output logic             rst_req_o,
  output logic             cal_req_o,
  output logic             cal_flag_o
);
  logic [1:0] sync_q;
  logic       cmp_s, slow_s, slow_prev_q, slow_edge;
  logic       active, blank, below_eff;
  logic       det_next, irq_next, rst_next, reload;
  logic       cal_pend_q;

  sg_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_i({slow_clk_i, cmp_below_i}), .q_o(sync_q)
  );
  assign cmp_s  = sync_q[0];
  assign slow_s = sync_q[1];

  always_ff @(posedge clk) begin
    if (rst) slow_prev_q <= 1'b0;
    else     slow_prev_q <= slow_s;
  end
  assign slow_edge = slow_s ^ slow_prev_q;

  sg_cfg #(.LVL_W(LVL_W)) u_cfg (
    .clk(clk), .rst(rst), .reload_i(reload),
    .fuse_mode_i(fuse_mode_i), .fuse_hyst_i(fuse_hyst_i), .fuse_level_i(fuse_level_i),
    .wr_en_i(wr_en_i), .wr_mode_i(wr_mode_i), .wr_hyst_i(wr_hyst_i), .wr_level_i(wr_level_i),
    .mode_o(mode_o), .hyst_o(hyst_en_o), .level_o(level_o)
  );

  assign active = mode_active(mode_o);

  sg_settle #(.MAIN_HOLD(MAIN_HOLD)) u_settle (
    .clk(clk), .rst(rst), .active_i(active), .slow_edge_i(slow_edge), .blank_o(blank)
  );

  assign below_eff = active && !blank && cmp_s;
  assign det_next  = (mode_o == MODE_FLAG) && below_eff;
  assign irq_next  = det_next && !det_o && !dbg_active_i;
  assign rst_next  = (mode_o == MODE_RESET) && below_eff && !dbg_active_i;
  assign reload    = rst_next && !rst_req_o && !cal_flag_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      det_o      <= 1'b0;
      irq_o      <= 1'b0;
      rst_req_o  <= 1'b0;
      cal_req_o  <= 1'b0;
      cal_pend_q <= 1'b0;
      cal_flag_o <= 1'b0;
    end else begin
      det_o     <= det_next;
      irq_o     <= irq_next;
      rst_req_o <= rst_next;
      cal_req_o <= reload;
      if (reload) begin
        cal_pend_q <= 1'b1;
      end else if (cal_pend_q && cal_done_i) begin
        cal_pend_q <= 1'b0;
        cal_flag_o <= 1'b1;
      end
    end
  end

  assert_off_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !active |=> (!det_o && !rst_req_o));
  assert_irq_fresh_R4: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (det_o && !$past(det_o)));
  assert_reset_no_flag_R5: assert property (@(posedge clk) disable iff (rst)
    rst_req_o |-> (!det_o && !irq_o));
  assert_settle_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    (blank && active) |=> (!det_o && !rst_req_o));
  assert_dbg_mask_R7: assert property (@(posedge clk) disable iff (rst)
    dbg_active_i |=> (!irq_o && !rst_req_o));
  assert_cal_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    cal_req_o |=> !cal_req_o);
endmodule

// File: tb/supply_guard_bench.sv
`timescale 1ns/1ps
module supply_guard_bench;
  localparam int LVL_W = 4;
  localparam int SETTLE_EDGES = 2 + 1 + 2 + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic slow_clk_i = 1'b0, cmp_below_i = 1'b0, dbg_active_i = 1'b0;
  logic [1:0] fuse_mode_i = 2'd0;
  logic fuse_hyst_i = 1'b1;
  logic [LVL_W-1:0] fuse_level_i = 4'd5;
  logic wr_en_i = 1'b0, wr_hyst_i = 1'b0, cal_done_i = 1'b0;
  logic [1:0] wr_mode_i = 2'd0;
  logic [LVL_W-1:0] wr_level_i = '0;
  logic [1:0] mode_o;
  logic hyst_en_o, det_o, irq_o, rst_req_o, cal_req_o, cal_flag_o;
  logic [LVL_W-1:0] level_o;

  int total = 0, bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  supply_guard u_supply_guard (
    .clk(clk), .rst(rst), .slow_clk_i(slow_clk_i), .cmp_below_i(cmp_below_i),
    .dbg_active_i(dbg_active_i), .fuse_mode_i(fuse_mode_i), .fuse_hyst_i(fuse_hyst_i),
    .fuse_level_i(fuse_level_i), .wr_en_i(wr_en_i), .wr_mode_i(wr_mode_i),
    .wr_hyst_i(wr_hyst_i), .wr_level_i(wr_level_i), .cal_done_i(cal_done_i),
    .mode_o(mode_o), .hyst_en_o(hyst_en_o), .level_o(level_o), .det_o(det_o),
    .irq_o(irq_o), .rst_req_o(rst_req_o), .cal_req_o(cal_req_o), .cal_flag_o(cal_flag_o)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] m, input logic h, input logic [LVL_W-1:0] l);
    wr_en_i = 1'b1; wr_mode_i = m; wr_hyst_i = h; wr_level_i = l;
    tick(1);
    wr_en_i = 1'b0;
  endtask

  function automatic logic exp_irq(input logic now_det, input logic prev_det, input logic dbg);
    return now_det && !prev_det && !dbg;
  endfunction

  initial begin
    void'($urandom(32'd4711));
    tick(3);
    rst = 1'b0;
    tick(1);
    // R1 reset state
    chk("R1 mode", mode_o, 0);
    chk("R1 hyst", hyst_en_o, 1);
    chk("R1 level", level_o, 5);
    chk("R1 outputs", {det_o, irq_o, rst_req_o, cal_req_o, cal_flag_o}, 0);

    // R2 mode 0 ignores a low supply
    cmp_below_i = 1'b1;
    tick(8);
    chk("R2 mode0 det", det_o, 0);
    chk("R2 mode0 rst", rst_req_o, 0);

    // R8/R9 write while off
    wr(2'd0, 1'b0, 4'd9);
    chk("R8 hyst write", hyst_en_o, 0);
    chk("R9 level write off", level_o, 9);

    // R2 reserved mode 3 with slow clock running
    wr(2'd3, 1'b0, 4'd9);
    for (int i = 0; i < 6; i++) begin slow_clk_i = ~slow_clk_i; tick(2); end
    chk("R2 mode3 det", det_o, 0);
    chk("R2 mode3 rst", rst_req_o, 0);
    tick(6);

    // R6 settling window after enable in flag mode
    wr(2'd2, 1'b0, 4'd9);
    chk("R8 mode write", mode_o, 2);
    tick(20);
    chk("R6 blank no slow edge", det_o, 0);
    slow_clk_i = ~slow_clk_i;
    tick(SETTLE_EDGES - 1);
    chk("R6 still blank", det_o, 0);
    tick(1);
    chk("R6 det after window", det_o, 1);
    chk("R4 irq on rise", irq_o, 1);
    tick(1);
    chk("R4 irq one cycle", irq_o, 0);
    chk("R3 det held", det_o, 1);

    // R3 self-clearing with three-edge latency
    cmp_below_i = 1'b0;
    tick(2);
    chk("R3 det before latency", det_o, 1);
    tick(1);
    chk("R3 det cleared", det_o, 0);
    tick(2);

    // R3/R4/R7 random phase against a delayed model
    begin
      logic d1 = 1'b0, d2 = 1'b0, d3 = 1'b0, d4 = 1'b0, g1 = 1'b0;
      for (int k = 0; k < 60; k++) begin
        logic nv = logic'($urandom & 1);
        logic ng = logic'(($urandom % 4) == 0);
        int hold = 1 + ($urandom % 4);
        for (int j = 0; j < hold; j++) begin
          chk("R3 random det", det_o, d3);
          chk("R4 random irq", irq_o, exp_irq(d3, d4, g1));
          d4 = d3; d3 = d2; d2 = d1; d1 = nv; g1 = ng;
          cmp_below_i = nv; dbg_active_i = ng;
          tick(1);
        end
      end
    end
    cmp_below_i = 1'b0; dbg_active_i = 1'b0;
    tick(4);

    // R9 level ignored while active, hysteresis accepted
    wr(2'd2, 1'b1, 4'd2);
    chk("R9 level locked", level_o, 9);
    chk("R8 hyst while active", hyst_en_o, 1);

    // R5/R10 first brown-out reset
    wr(2'd1, 1'b1, 4'd9);
    cmp_below_i = 1'b1;
    tick(2);
    chk("R5 rst latency", rst_req_o, 0);
    tick(1);
    chk("R5 rst asserted", rst_req_o, 1);
    chk("R5 no det", det_o, 0);
    chk("R10 cal req", cal_req_o, 1);
    tick(1);
    chk("R10 cal pulse", cal_req_o, 0);
    chk("R10 reload mode", mode_o, 0);
    chk("R10 reload level", level_o, 5);
    chk("R2 off after reload", rst_req_o, 0);
    chk("R10 flag pending", cal_flag_o, 0);
    cal_done_i = 1'b1;
    tick(1);
    cal_done_i = 1'b0;
    chk("R10 flag set", cal_flag_o, 1);

    // R7/R10 second brown-out with debug mask
    cmp_below_i = 1'b0;
    wr(2'd1, 1'b0, 4'd12);
    chk("R9 level write off again", level_o, 12);
    tick(3);
    slow_clk_i = ~slow_clk_i;
    tick(8);
    dbg_active_i = 1'b1;
    cmp_below_i = 1'b1;
    tick(6);
    chk("R7 rst masked", rst_req_o, 0);
    dbg_active_i = 1'b0;
    tick(1);
    chk("R7 rst after unmask", rst_req_o, 1);
    chk("R10 no second cal", cal_req_o, 0);
    tick(1);
    chk("R10 mode kept", mode_o, 1);
    chk("R10 level kept", level_o, 12);
    chk("R10 hyst kept", hyst_en_o, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule